// File: doc/BRIEF.md
# Half-Flash Converter Bus Sequencer

This block lets a host start conversions on an external 8-bit half-flash analog-to-digital converter and read the results back. The converter has no clock of its own. It responds only to active-low chip-select, write and read strobes. It reports completion either on an active-low interrupt line or on an active-high ready line. The sequencer drives the strobes and enforces every pulse width, access delay and recovery gap in whole cycles of its own clock. It then hands the captured result byte and the overflow bit to the host with a one-cycle valid pulse.

Two conversion styles are supported, and the choice is made with `mode_wr_i` when a start request is accepted. In write-then-read style, a write pulse starts the comparison. The block then waits for the interrupt line to fall, or for a comparison-time timeout, and afterwards issues a read pulse. In read-only style, the read strobe is lowered together with chip select and held until the ready line is seen high. All cycle counts are derived at elaboration from a clock-period parameter given in nanoseconds. The interrupt and ready lines are treated as asynchronous inputs and each passes through a synchronizer of `SYNC_STAGES` flops.

Top module: `adc_hf_ctrl`

## Requirements
- R1: While the internal reset is active and after it is released, cv_cs_n, cv_wr_n and cv_rd_n are high, and busy_o, valid_o, timeout_o, ovf_o and data_o are all zero.
- R2: When a start is accepted with mode_wr_i=1, cv_wr_n and cv_cs_n go low in the next cycle. cv_wr_n stays low for exactly ceil(600 ns / CLK_NS) cycles, which is 60 at the default 10 ns.
- R3: After the write pulse, cv_rd_n falls three cycles after the first clock edge that samples cv_int_n low (two synchronizer flops plus the state register). It then stays low for ceil(600 ns / CLK_NS) cycles.
- R4: If the synchronized cv_int_n has not been seen low within ceil(1300 ns / CLK_NS)+1 cycles after cv_wr_n rises (131 at the default), cv_rd_n is lowered anyway and timeout_o is set. timeout_o stays set until reset. An interrupt recognised on the final cycle of that window wins, and in that case no timeout is flagged.
- R5: When a start is accepted with mode_wr_i=0, cv_cs_n and cv_rd_n go low in the next cycle. cv_rdy is ignored for the first ceil(100 ns / CLK_NS) cycles. After cv_rdy is recognised high through the synchronizer, cv_rd_n is held low for ceil(30 ns / CLK_NS) further cycles.
- R6: data_o and ovf_o are loaded from cv_data and from the inverse of cv_ovf_n, as sampled on the final clock edge of the read pulse. valid_o is high for exactly the following cycle. The outputs hold their value until the next capture.
- R7: After cv_rd_n rises, cv_cs_n stays high for at least ceil(max(500, 225, 200) ns / CLK_NS) cycles before another conversion can start. busy_o is high from the cycle after start acceptance until that recovery interval has ended.
- R8: A start_i pulse that arrives while busy_o is high is remembered. It starts the next conversion on the first idle cycle after recovery.
- R9: cv_wr_n and cv_rd_n are never low together, and neither is ever low while cv_cs_n is high.
- R10: The conversion style is taken from mode_wr_i only when a start is accepted. Changing mode_wr_i during a conversion has no effect on that conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_NS |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Conversion request, sampled each cycle |
| mode_wr_i | input | 1 | 1 = write-then-read style, 0 = read-only style |
| cv_int_n | input | 1 | Converter completion interrupt, active low, asynchronous |
| cv_rdy | input | 1 | Converter ready level, high when the result is on the bus, asynchronous |
| cv_data | input | DATA_W | Converter result bus |
| cv_ovf_n | input | 1 | Converter overflow output, active low |
| cv_cs_n | output | 1 | Chip select to converter, active low |
| cv_wr_n | output | 1 | Write strobe to converter, active low |
| cv_rd_n | output | 1 | Read strobe to converter, active low |
| data_o | output | DATA_W | Last captured result |
| ovf_o | output | 1 | Last captured overflow, active high |
| valid_o | output | 1 | One-cycle pulse after a capture |
| busy_o | output | 1 | Conversion or recovery in progress |
| timeout_o | output | 1 | Sticky flag: a comparison-time timeout has occurred |

## Verification
The write-then-read sequence is exercised with the interrupt arriving early, arriving typically, arriving on the last cycle the window accepts, arriving one cycle later, and never arriving. The last three runs separate an interrupt that wins the race from a timeout that fires, both in the cycle the read strobe falls and in the timeout flag. Read-only runs pair a slow ready with a ready line that is already high at start. That second case shows whether the blanking window really masks the stale level. One run changes the mode input and requests a new start halfway through a conversion, which checks that the mode is sampled only at start and that the queued request is taken straight after recovery. The result bus carries its inverse until the final read cycle, so a capture taken on any earlier edge is seen as a mismatch.

// File: rtl/adc_hf_pkg.sv
package adc_hf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_LOW,
    ST_INT_WAIT,
    ST_RD_LOW,
    ST_RDY_BLANK,
    ST_RDY_WAIT,
    ST_RDY_HOLD,
    ST_RECOVER
  } seq_state_e;

  // round a duration in ns up to whole clock cycles
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period_ns);
    return (ns + period_ns - 1) / period_ns;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_hf_sync.sv
module adc_hf_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] ff_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q[0] <= RST_VAL;
        else        ff_q[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q[i] <= RST_VAL;
        else        ff_q[i] <= ff_q[i-1];
      end
    end
  end

  assign q = ff_q[STAGES-1];

endmodule

// File: rtl/adc_hf_timer.sv
module adc_hf_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/adc_hf_capture.sv
module adc_hf_capture #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] bus_i,
  input  logic              ovf_n_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ovf_o,
  output logic              valid_o
);

  logic [DATA_W-1:0] data_q;
  logic              ovf_q;
  logic              valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      ovf_q  <= 1'b0;
    end else if (cap_en) begin
      data_q <= bus_i;
      ovf_q  <= ~ovf_n_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= cap_en;
  end

  assign data_o  = data_q;
  assign ovf_o   = ovf_q;
  assign valid_o = valid_q;

  // R6: one-cycle valid pulse, result only moves together with valid
  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
  assert_data_moves_with_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_q) |-> valid_q);

endmodule

// File: rtl/adc_hf_fsm.sv
module adc_hf_fsm
  import adc_hf_pkg::*;
#(
  parameter int unsigned TMR_W      = 8,
  parameter int unsigned WR_CYC     = 60,
  parameter int unsigned WR_MAX_CYC = 5000,
  parameter int unsigned RD_CYC     = 60,
  parameter int unsigned TO_CYC     = 131,
  parameter int unsigned BLANK_CYC  = 10,
  parameter int unsigned ACC_CYC    = 3,
  parameter int unsigned REC_CYC    = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             mode_wr_i,
  input  logic             int_n_s,
  input  logic             rdy_s,
  input  logic             tmr_expired,
  output logic             tmr_load,
  output logic [TMR_W-1:0] tmr_val,
  output logic             cap_en,
  output logic             cs_n,
  output logic             wr_n,
  output logic             rd_n,
  output logic             busy,
  output logic             timeout
);

  localparam int unsigned WRR_W = $clog2(WR_MAX_CYC + 2);
  localparam int unsigned CSR_W = $clog2(REC_CYC + 2);

  seq_state_e state_q, state_d;
  logic pend_q, pend_d;
  logic to_q, to_d;
  logic cs_n_q, cs_n_d;
  logic wr_n_q, wr_n_d;
  logic rd_n_q, rd_n_d;
  logic accept;

  // next-state logic
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    cap_en   = 1'b0;
    accept   = 1'b0;
    to_d     = to_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i || pend_q) begin
          accept   = 1'b1;
          tmr_load = 1'b1;
          if (mode_wr_i) begin
            state_d = ST_WR_LOW;
            tmr_val = TMR_W'(WR_CYC - 1);
          end else begin
            state_d = ST_RDY_BLANK;
            tmr_val = TMR_W'(BLANK_CYC - 1);
          end
        end
      end
      ST_WR_LOW: begin
        if (tmr_expired) begin
          state_d  = ST_INT_WAIT;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(TO_CYC - 1);
        end
      end
      ST_INT_WAIT: begin
        if (!int_n_s || tmr_expired) begin
          state_d  = ST_RD_LOW;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(RD_CYC - 1);
          if (int_n_s) to_d = 1'b1;
        end
      end
      ST_RD_LOW: begin
        if (tmr_expired) begin
          cap_en   = 1'b1;
          state_d  = ST_RECOVER;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(REC_CYC - 1);
        end
      end
      ST_RDY_BLANK: begin
        if (tmr_expired) state_d = ST_RDY_WAIT;
      end
      ST_RDY_WAIT: begin
        if (rdy_s) begin
          state_d  = ST_RDY_HOLD;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(ACC_CYC - 1);
        end
      end
      ST_RDY_HOLD: begin
        if (tmr_expired) begin
          cap_en   = 1'b1;
          state_d  = ST_RECOVER;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(REC_CYC - 1);
        end
      end
      ST_RECOVER: begin
        if (tmr_expired) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    pend_d = pend_q;
    if (accept)                          pend_d = 1'b0;
    if (start_i && (state_q != ST_IDLE)) pend_d = 1'b1;
  end

  // strobes are registered from the next state, so they change with the state
  always_comb begin
    cs_n_d = (state_d == ST_IDLE) || (state_d == ST_RECOVER);
    wr_n_d = (state_d != ST_WR_LOW);
    rd_n_d = !((state_d == ST_RD_LOW)    || (state_d == ST_RDY_BLANK) ||
               (state_d == ST_RDY_WAIT)  || (state_d == ST_RDY_HOLD));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
      to_q    <= 1'b0;
      cs_n_q  <= 1'b1;
      wr_n_q  <= 1'b1;
      rd_n_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      to_q    <= to_d;
      cs_n_q  <= cs_n_d;
      wr_n_q  <= wr_n_d;
      rd_n_q  <= rd_n_d;
    end
  end

  assign cs_n    = cs_n_q;
  assign wr_n    = wr_n_q;
  assign rd_n    = rd_n_q;
  assign busy    = (state_q != ST_IDLE);
  assign timeout = to_q;

  // run-length counters that watch the strobes
  logic [WRR_W-1:0] wr_run_q;
  logic [CSR_W-1:0] cs_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_run_q <= '0;
    end else if (!wr_n_q) begin
      if (wr_run_q != WRR_W'(WR_MAX_CYC + 1)) wr_run_q <= wr_run_q + 1'b1;
    end else begin
      wr_run_q <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_run_q <= CSR_W'(REC_CYC + 1);
    end else if (cs_n_q) begin
      if (cs_run_q != CSR_W'(REC_CYC + 1)) cs_run_q <= cs_run_q + 1'b1;
    end else begin
      cs_run_q <= '0;
    end
  end

  // R2: write pulse between its minimum and maximum width
  assert_wr_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n_q) |-> (wr_run_q >= WRR_W'(WR_CYC)) && (wr_run_q <= WRR_W'(WR_MAX_CYC)));
  // R7: recovery gap before chip select falls again
  assert_recovery_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_q) |-> (cs_run_q >= CSR_W'(REC_CYC)));
  // R7: chip select only low while busy
  assert_cs_within_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_q |-> busy);
  // R9: strobes exclusive and qualified by chip select
  assert_strobes_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!wr_n_q && !rd_n_q));
  assert_strobes_need_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n_q || !rd_n_q) |-> !cs_n_q);
  // R4: timeout flag is sticky
  assert_timeout_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    to_q |=> to_q);

endmodule

// File: rtl/adc_hf_ctrl.sv
module adc_hf_ctrl
  import adc_hf_pkg::*;
#(
  parameter int unsigned CLK_NS       = 10,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned WR_MIN_NS    = 600,
  parameter int unsigned WR_MAX_NS    = 50000,
  parameter int unsigned RD_MIN_NS    = 600,
  parameter int unsigned RD_ACC_NS    = 320,
  parameter int unsigned CMP_MAX_NS   = 1300,
  parameter int unsigned RDY_BLANK_NS = 100,
  parameter int unsigned RDY_ACC_NS   = 30,
  parameter int unsigned GAP_NS       = 500,
  parameter int unsigned INT_REL_NS   = 225,
  parameter int unsigned BUS_FLOAT_NS = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              mode_wr_i,
  input  logic              cv_int_n,
  input  logic              cv_rdy,
  input  logic [DATA_W-1:0] cv_data,
  input  logic              cv_ovf_n,
  output logic              cv_cs_n,
  output logic              cv_wr_n,
  output logic              cv_rd_n,
  output logic [DATA_W-1:0] data_o,
  output logic              ovf_o,
  output logic              valid_o,
  output logic              busy_o,
  output logic              timeout_o
);

  localparam int unsigned WR_CYC     = ns_to_cyc(WR_MIN_NS, CLK_NS);
  localparam int unsigned WR_MAX_CYC = WR_MAX_NS / CLK_NS;
  localparam int unsigned RD_CYC     = ns_to_cyc(max2(RD_MIN_NS, RD_ACC_NS), CLK_NS);
  localparam int unsigned TO_CYC     = ns_to_cyc(CMP_MAX_NS, CLK_NS) + 1;
  localparam int unsigned BLANK_CYC  = ns_to_cyc(RDY_BLANK_NS, CLK_NS);
  localparam int unsigned ACC_CYC    = ns_to_cyc(RDY_ACC_NS, CLK_NS);
  localparam int unsigned REC_CYC    = ns_to_cyc(max2(GAP_NS, max2(INT_REL_NS, BUS_FLOAT_NS)), CLK_NS);
  localparam int unsigned MAX_CYC    = max2(max2(max2(WR_CYC, RD_CYC), max2(TO_CYC, BLANK_CYC)),
                                            max2(ACC_CYC, REC_CYC));
  localparam int unsigned TMR_W      = $clog2(MAX_CYC + 1);

  logic             rst_ni;
  logic             int_n_s;
  logic             rdy_s;
  logic             tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic             tmr_expired;
  logic             cap_en;

  // asynchronous assert, synchronous release
  adc_hf_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_ni)
  );

  adc_hf_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_int_sync (
    .clk(clk), .rst_n(rst_ni), .d(cv_int_n), .q(int_n_s)
  );

  adc_hf_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rdy_sync (
    .clk(clk), .rst_n(rst_ni), .d(cv_rdy), .q(rdy_s)
  );

  adc_hf_timer #(.W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_ni), .load(tmr_load), .load_val(tmr_val), .expired(tmr_expired)
  );

  adc_hf_fsm #(
    .TMR_W(TMR_W), .WR_CYC(WR_CYC), .WR_MAX_CYC(WR_MAX_CYC), .RD_CYC(RD_CYC),
    .TO_CYC(TO_CYC), .BLANK_CYC(BLANK_CYC), .ACC_CYC(ACC_CYC), .REC_CYC(REC_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_ni), .start_i(start_i), .mode_wr_i(mode_wr_i),
    .int_n_s(int_n_s), .rdy_s(rdy_s), .tmr_expired(tmr_expired),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .cap_en(cap_en),
    .cs_n(cv_cs_n), .wr_n(cv_wr_n), .rd_n(cv_rd_n), .busy(busy_o), .timeout(timeout_o)
  );

  adc_hf_capture #(.DATA_W(DATA_W)) u_capture (
    .clk(clk), .rst_n(rst_ni), .cap_en(cap_en), .bus_i(cv_data), .ovf_n_i(cv_ovf_n),
    .data_o(data_o), .ovf_o(ovf_o), .valid_o(valid_o)
  );

  // R6: a capture only ever follows a read pulse
  assert_valid_after_read_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(valid_o) |-> $rose(cv_rd_n));

endmodule

// File: tb/tb_adc_hf_ctrl.sv
module tb_adc_hf_ctrl;

  localparam int CLK_PERIOD_NS = 10;
  localparam int WRC = (600  + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int RDC = (600  + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int TOC = (1300 + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS + 1;
  localparam int BLK = (100  + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int ACC = (30   + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int REC = (500  + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int RDY_FALL = 4;

  logic       clk;
  logic       rst_n;
  logic       start_i;
  logic       mode_wr_i;
  logic       cv_int_n;
  logic       cv_rdy;
  logic [7:0] cv_data;
  logic       cv_ovf_n;
  logic       cv_cs_n, cv_wr_n, cv_rd_n;
  logic [7:0] data_o;
  logic       ovf_o, valid_o, busy_o, timeout_o;

  int checks = 0;
  int errors = 0;

  // expected persistent outputs
  logic [7:0] exp_data = 8'h00;
  logic       exp_ovf  = 1'b0;
  logic       exp_to   = 1'b0;

  // converter model settings
  int int_delay = -1;
  int rdy_hi_dly = 20;

  adc_hf_ctrl #(.CLK_NS(CLK_PERIOD_NS)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_wr_i(mode_wr_i),
    .cv_int_n(cv_int_n), .cv_rdy(cv_rdy), .cv_data(cv_data), .cv_ovf_n(cv_ovf_n),
    .cv_cs_n(cv_cs_n), .cv_wr_n(cv_wr_n), .cv_rd_n(cv_rd_n),
    .data_o(data_o), .ovf_o(ovf_o), .valid_o(valid_o), .busy_o(busy_o), .timeout_o(timeout_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD_NS/2) clk = ~clk;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // behavioural converter: reacts to strobes seen at falling clock edges
  initial begin
    int   cyc_n = 0;
    int   int_at = -1, rlo_at = -1, rhi_at = -1;
    logic wr_prev = 1'b1, rd_prev = 1'b1;
    cv_int_n = 1'b1;
    cv_rdy   = 1'b1;
    forever begin
      @(negedge clk);
      cyc_n++;
      if (!wr_prev && cv_wr_n) int_at = (int_delay >= 0) ? cyc_n + int_delay : -1;
      if (!rd_prev && cv_rd_n) begin
        cv_int_n = 1'b1;
        int_at   = -1;
      end
      if (rd_prev && !cv_rd_n) begin
        rlo_at = cyc_n + RDY_FALL;
        rhi_at = cyc_n + rdy_hi_dly;
      end
      if (cyc_n == int_at) cv_int_n = 1'b0;
      if (cyc_n == rlo_at) cv_rdy = 1'b0;
      if (cyc_n == rhi_at) cv_rdy = 1'b1;
      wr_prev = cv_wr_n;
      rd_prev = cv_rd_n;
    end
  end

  // one conversion, checked on every clock; called at an idle falling edge
  task automatic run_conv(input bit mode, input bit drive_start, input int dly,
                          input logic [7:0] val, input bit ovfn,
                          input bit pend_req, input bit toggle_mode, input string scen);
    int  r0, vk, rd_lo, rd_hi, a0;
    bit  late;
    late = 1'b0;
    if (mode) begin
      int_delay = dly;
      late  = !(dly >= 0 && dly + 3 <= TOC);
      r0    = late ? (WRC + 1 + TOC) : (WRC + 1 + dly + 3);
      rd_lo = r0;
      rd_hi = r0 + RDC - 1;
      vk    = r0 + RDC;
    end else begin
      rdy_hi_dly = dly;
      a0    = ((1 + dly + 2) > (BLK + 1) ? (1 + dly + 2) : (BLK + 1)) + 1;
      r0    = 0;
      rd_lo = 1;
      rd_hi = a0 + ACC - 1;
      vk    = a0 + ACC;
    end
    cv_data   = ~val;
    cv_ovf_n  = ~ovfn;
    mode_wr_i = mode;
    if (drive_start) start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 1; k <= vk + REC; k++) begin
      string rtag;
      rtag = mode ? (late ? "R4" : "R3") : "R5";
      if (k == vk - 1) begin
        cv_data  = val;
        cv_ovf_n = ovfn;
      end
      if (late && k >= r0) exp_to = 1'b1;
      if (k >= vk) begin
        exp_data = val;
        exp_ovf  = ~ovfn;
      end
      chk({"R2 ", scen}, "wr_n", cv_wr_n, !(mode && k >= 1 && k <= WRC));
      chk({rtag, " ", scen}, "rd_n", cv_rd_n, !(k >= rd_lo && k <= rd_hi));
      chk({"R9 ", scen}, "cs_n", cv_cs_n, !(k < vk));
      chk({"R7 ", scen}, "busy", busy_o, (k < vk + REC));
      chk({"R6 ", scen}, "valid", valid_o, (k == vk));
      chk({"R6 ", scen}, "data", data_o, exp_data);
      chk({"R6 ", scen}, "ovf", ovf_o, exp_ovf);
      chk({"R4 ", scen}, "timeout", timeout_o, exp_to);
      if (toggle_mode && k == 3) mode_wr_i = ~mode;
      if (pend_req && k == 5) start_i = 1'b1;
      if (pend_req && k == 6) start_i = 1'b0;
      if (k < vk + REC) @(negedge clk);
    end
  endtask

  initial begin
    start_i   = 1'b0;
    mode_wr_i = 1'b1;
    cv_data   = 8'h00;
    cv_ovf_n  = 1'b1;
    rst_n     = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state while held
    chk("R1", "cs_n", cv_cs_n, 1);
    chk("R1", "wr_n", cv_wr_n, 1);
    chk("R1", "rd_n", cv_rd_n, 1);
    chk("R1", "busy", busy_o, 0);
    chk("R1", "valid", valid_o, 0);
    chk("R1", "timeout", timeout_o, 0);
    chk("R1", "ovf", ovf_o, 0);
    chk("R1", "data", data_o, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1", "cs_n after release", cv_cs_n, 1);
    chk("R1", "busy after release", busy_o, 0);

    run_conv(1'b1, 1'b1, 80,      8'hA5, 1'b1, 1'b0, 1'b0, "typ-int");
    run_conv(1'b1, 1'b1, 1,       8'h5A, 1'b0, 1'b0, 1'b0, "fast-int");
    run_conv(1'b1, 1'b1, TOC - 3, 8'h3C, 1'b1, 1'b0, 1'b0, "edge-int");
    run_conv(1'b0, 1'b1, 40,      8'h81, 1'b1, 1'b0, 1'b0, "slow-rdy");
    run_conv(1'b0, 1'b1, 6,       8'h7E, 1'b0, 1'b0, 1'b0, "stale-rdy");
    run_conv(1'b1, 1'b1, 5,       8'hC3, 1'b1, 1'b1, 1'b1, "R10 mode-toggle");
    run_conv(1'b0, 1'b0, 30,      8'h12, 1'b1, 1'b0, 1'b0, "R8 queued");
    run_conv(1'b1, 1'b1, TOC - 2, 8'hF0, 1'b0, 1'b0, 1'b0, "late-int");
    run_conv(1'b1, 1'b1, -1,      8'hFF, 1'b1, 1'b0, 1'b0, "no-int");

    repeat (4) @(negedge clk);
    chk("R7", "idle busy", busy_o, 0);
    chk("R4", "sticky timeout", timeout_o, 1);
    chk("R6", "held data", data_o, 8'hFF);
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1..: actual=running expected=finished");
    summary();
    $finish;
  end

endmodule